// File: doc/BRIEF.md
# Button-to-LED Message Handshake Sequencer

This block replaces a small processor on the peripheral side of a shared-LED arrangement. A debounced button press starts a fixed two-round exchange. It posts a button message into an outbound mailbox and waits for the lock holder on the far side to acknowledge. Once that acknowledge arrives, the far side holds the lock, so the block writes the shared LEDs. It then posts an LED-ready message and waits for a closing acknowledge before it returns to idle.

Every message is one word made of four ASCII bytes. Byte 0 sits in bits [7:0] and holds the message type. Byte 1 sits in bits [15:8] and holds the processor digit, which is `"0"` plus `PROC_ID`. Byte 2 sits in bits [23:16]. Byte 3 sits in bits [31:24] and is always null.

The block is defensive about the far side. It drops replies addressed to another processor. A negative acknowledge or a silent peer returns it to idle with a one-cycle error pulse. The value it writes to the LEDs is a count of completed exchanges.

Top module: `btn_led_handshake`

## Requirements
- R1: A 0-to-1 transition of `btn_level` seen in idle starts an exchange whose first message is 0x42 ('B') in bits [7:0], the processor digit in bits [15:8], 0x30 ('0') in bits [23:16] and 0x00 in bits [31:24].
- R2: `tx_wr` is high for exactly one cycle per message, and only in a cycle where `tx_empty` is high. While `tx_empty` is low, the message waits.
- R3: An acknowledge is 0x41 ('A') in bits [7:0], the processor digit in [15:8], 0x41 in [23:16] and 0x00 in [31:24]. The LEDs change only in the cycle after the first acknowledge is popped, and they then show the completed-exchange count plus one (a 1 lights an LED).
- R4: After the first acknowledge, the next message sent is 0x4C ('L') in bits [7:0], the processor digit in [15:8], 0x30 in [23:16] and 0x00 in [31:24].
- R5: A second acknowledge returns the block to idle (`busy` low) and advances the completed-exchange count. The LEDs keep the value they were given.
- R6: A reply with 0x4E ('N') in bits [7:0] and the processor digit in [15:8] pops, returns the block to idle and raises `err_pulse` for one cycle in the first idle cycle. The LEDs are left unchanged.
- R7: A reply whose bits [15:8] are not the processor digit is popped and dropped. The wait goes on without restarting its timeout.
- R8: If `TIMEOUT` cycles pass in a wait state with no acknowledge or negative acknowledge popped, the block returns to idle with a one-cycle `err_pulse`. The count does not advance.
- R9: Button transitions while `busy` is high start nothing. A level that stays high does not retrigger, and neither does a level already high when reset ends.
- R10: `rx_rd` is high only in a waiting cycle with `rx_valid` high. Replies that arrive while idle or while sending stay in the mailbox.
- R11: During and right after reset, `led_out` is 0 and `busy`, `err_pulse` and `tx_wr` are low.
- R12: The completed-exchange count is 4 bits wide and wraps from 15 to 0, so the sixteenth exchange lights 0, the seventeenth lights 1, and so on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| btn_level | input | 1 | Debounced button level |
| tx_empty | input | 1 | Outbound mailbox can take a word |
| tx_wr | output | 1 | Write strobe into the outbound mailbox |
| tx_data | output | WORD_W | Outbound message word |
| rx_valid | input | 1 | Inbound mailbox holds a word |
| rx_rd | output | 1 | Pop strobe for the inbound mailbox |
| rx_data | input | WORD_W | Word at the head of the inbound mailbox |
| led_out | output | LED_W | Shared LED drive, 1 = on |
| busy | output | 1 | An exchange is in progress |
| err_pulse | output | 1 | One-cycle pulse on negative acknowledge or timeout |

## Verification
The bench builds the block with `PROC_ID` = 1, so the digit '1' is its own and a reply carrying '0' is foreign. It uses `TIMEOUT` = 12, which lets a silent peer expire in either wait state within a few dozen cycles. The bench runs more than sixteen full exchanges, which carries the LED count through its wrap. Replies queued while idle show that words are popped only in wait states.

// File: rtl/hs_pkg.sv
package hs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEND_BTN,
        ST_WAIT_GRANT,
        ST_SEND_LED,
        ST_WAIT_DONE
    } seq_state_e;

    typedef enum logic [1:0] {
        RSP_JUNK,
        RSP_ACK,
        RSP_NACK,
        RSP_FOREIGN
    } rsp_kind_e;

    localparam logic [7:0] CH_BTN  = 8'h42;
    localparam logic [7:0] CH_LED  = 8'h4C;
    localparam logic [7:0] CH_ACK  = 8'h41;
    localparam logic [7:0] CH_NACK = 8'h4E;
    localparam logic [7:0] CH_ZERO = 8'h30;
    localparam logic [7:0] CH_NUL  = 8'h00;

    function automatic logic [7:0] digit_char(input int unsigned id);
        return CH_ZERO + 8'(id);
    endfunction

endpackage

// File: rtl/msg_encoder.sv
module msg_encoder #(
    parameter int unsigned PROC_ID = 0,
    parameter int unsigned WORD_W  = 32
) (
    input  logic              sel_led,
    output logic [WORD_W-1:0] word
);
    import hs_pkg::*;

    localparam logic [7:0] DIGIT = digit_char(PROC_ID);

    always_comb begin
        word = WORD_W'({CH_NUL, CH_ZERO, DIGIT, (sel_led ? CH_LED : CH_BTN)});
    end
endmodule

// File: rtl/resp_decoder.sv
module resp_decoder #(
    parameter int unsigned PROC_ID = 0,
    parameter int unsigned WORD_W  = 32
) (
    input  logic [WORD_W-1:0] word,
    output hs_pkg::rsp_kind_e kind
);
    import hs_pkg::*;

    localparam logic [7:0] DIGIT = digit_char(PROC_ID);

    logic [7:0] b_type, b_proc, b_data, b_term;

    always_comb begin
        b_type = word[7:0];
        b_proc = word[15:8];
        b_data = word[23:16];
        b_term = word[31:24];
        if (b_proc != DIGIT) begin
            kind = RSP_FOREIGN;
        end else if (b_type == CH_ACK && b_data == CH_ACK && b_term == CH_NUL) begin
            kind = RSP_ACK;
        end else if (b_type == CH_NACK) begin
            kind = RSP_NACK;
        end else begin
            kind = RSP_JUNK;
        end
    end
endmodule

// File: rtl/resp_timer.sv
module resp_timer #(
    parameter int unsigned LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic expired
);
    localparam int unsigned CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        expired = run && (cnt_q == LAST);
        cnt_d   = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (run && !expired) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/btn_led_handshake.sv
module btn_led_handshake #(
    parameter int unsigned PROC_ID = 0,
    parameter int unsigned WORD_W  = 32,
    parameter int unsigned LED_W   = 4,
    parameter int unsigned TIMEOUT = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              btn_level,
    input  logic              tx_empty,
    output logic              tx_wr,
    output logic [WORD_W-1:0] tx_data,
    input  logic              rx_valid,
    output logic              rx_rd,
    input  logic [WORD_W-1:0] rx_data,
    output logic [LED_W-1:0]  led_out,
    output logic              busy,
    output logic              err_pulse
);
    import hs_pkg::*;

    typedef struct packed {
        seq_state_e       st;
        logic             btn_prev;
        logic [LED_W-1:0] led;
        logic [LED_W-1:0] done_cnt;
        logic             err;
    } regs_t;

    localparam regs_t RESET_VAL = '{
        st: ST_IDLE, btn_prev: 1'b1, led: '0, done_cnt: '0, err: 1'b0
    };

    regs_t     r_d, r_q;
    rsp_kind_e kind;
    logic      sel_led;
    logic      tmr_clear, tmr_run, tmr_expired;
    logic      accepted;

    msg_encoder #(.PROC_ID(PROC_ID), .WORD_W(WORD_W)) u_enc (
        .sel_led (sel_led),
        .word    (tx_data)
    );

    resp_decoder #(.PROC_ID(PROC_ID), .WORD_W(WORD_W)) u_dec (
        .word (rx_data),
        .kind (kind)
    );

    resp_timer #(.LIMIT(TIMEOUT)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (tmr_clear),
        .run     (tmr_run),
        .expired (tmr_expired)
    );

    always_comb begin
        r_d          = r_q;
        r_d.err      = 1'b0;
        r_d.btn_prev = btn_level;
        tx_wr        = 1'b0;
        rx_rd        = 1'b0;
        tmr_clear    = 1'b0;
        tmr_run      = 1'b0;
        sel_led      = (r_q.st == ST_SEND_LED);
        accepted     = rx_valid && (kind == RSP_ACK || kind == RSP_NACK);

        unique case (r_q.st)
            ST_IDLE: begin
                if (btn_level && !r_q.btn_prev) r_d.st = ST_SEND_BTN;
            end
            ST_SEND_BTN, ST_SEND_LED: begin
                if (tx_empty) begin
                    tx_wr     = 1'b1;
                    tmr_clear = 1'b1;
                    r_d.st    = (r_q.st == ST_SEND_BTN) ? ST_WAIT_GRANT : ST_WAIT_DONE;
                end
            end
            ST_WAIT_GRANT, ST_WAIT_DONE: begin
                tmr_run = 1'b1;
                rx_rd   = rx_valid;
                if (accepted && kind == RSP_ACK) begin
                    if (r_q.st == ST_WAIT_GRANT) begin
                        r_d.led = r_q.done_cnt + 1'b1;
                        r_d.st  = ST_SEND_LED;
                    end else begin
                        r_d.done_cnt = r_q.done_cnt + 1'b1;
                        r_d.st       = ST_IDLE;
                    end
                end else if (accepted) begin
                    r_d.err = 1'b1;
                    r_d.st  = ST_IDLE;
                end else if (tmr_expired) begin
                    r_d.err = 1'b1;
                    r_d.st  = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RESET_VAL;
        else        r_q <= r_d;
    end

    assign led_out   = r_q.led;
    assign busy      = (r_q.st != ST_IDLE);
    assign err_pulse = r_q.err;

endmodule

// File: rtl/btn_led_handshake_chk.sv
module btn_led_handshake_chk #(
    parameter int unsigned PROC_ID = 0,
    parameter int unsigned WORD_W  = 32,
    parameter int unsigned LED_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tx_empty,
    input logic              tx_wr,
    input logic [WORD_W-1:0] tx_data,
    input logic              rx_valid,
    input logic              rx_rd,
    input logic [LED_W-1:0]  led_out,
    input logic              busy,
    input logic              err_pulse
);
    localparam logic [7:0] DIGIT = 8'(8'h30 + PROC_ID);

    // R2
    tx_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr |-> tx_empty);

    // R1
    tx_format_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr |-> (tx_data[15:8] == DIGIT && tx_data[31:24] == 8'h00 && tx_data[23:16] == 8'h30));

    // R10
    rx_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_rd |-> (rx_valid && busy));

    // R6
    err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |=> !err_pulse);

    // R8
    err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> !busy);

    // R3
    led_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(led_out) |-> $past(rx_rd));

endmodule

bind btn_led_handshake btn_led_handshake_chk #(
    .PROC_ID(PROC_ID), .WORD_W(WORD_W), .LED_W(LED_W)
) u_chk (.*);

// File: tb/btn_led_handshake_test.sv
`timescale 1ns/1ps
module btn_led_handshake_test;
    localparam int PROC = 1;
    localparam int TMO  = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        btn_level = 1'b0;
    logic        tx_empty = 1'b1;
    logic        tx_wr;
    logic [31:0] tx_data;
    logic        rx_valid = 1'b0;
    logic        rx_rd;
    logic [31:0] rx_data = '0;
    logic [3:0]  led_out;
    logic        busy;
    logic        err_pulse;

    always #2 clk = ~clk;

    btn_led_handshake #(.PROC_ID(PROC), .WORD_W(32), .LED_W(4), .TIMEOUT(TMO)) uut (.*);

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;
    string cur    = "R11";
    logic [31:0] rxq[$];

    // behavioural model state
    int m_ph   = 0;   // 0 idle, 1 send button msg, 2 wait grant, 3 send led msg, 4 wait done
    bit m_prev = 1;
    int m_led  = 0;
    int m_cnt  = 0;
    int m_k    = 0;
    bit m_err  = 0;

    function automatic logic [31:0] mk(input logic [7:0] t, input logic [7:0] p, input logic [7:0] d);
        return {8'h00, d, p, t};
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic step(input logic b, input logic te);
        int n_ph, n_led, n_cnt, n_k;
        bit n_err, e_wr, e_rd, pop;
        logic [31:0] e_data;
        logic [7:0] my;
        @(negedge clk);
        btn_level = b;
        tx_empty  = te;
        rx_valid  = (rxq.size() != 0);
        rx_data   = rx_valid ? rxq[0] : 32'h0;
        #1;
        my = 8'(8'h30 + PROC);
        n_ph = m_ph; n_led = m_led; n_cnt = m_cnt; n_k = m_k; n_err = 0;
        e_wr = 0; e_rd = 0; e_data = 'x;
        if (m_ph == 0) begin
            if (b && !m_prev) n_ph = 1;
        end else if (m_ph == 1 || m_ph == 3) begin
            if (te) begin
                e_wr = 1;
                e_data = mk((m_ph == 3) ? 8'h4C : 8'h42, my, 8'h30);
                n_ph = m_ph + 1;
                n_k = 0;
            end
        end else begin
            bit took = 0;
            if (rx_valid) begin
                e_rd = 1;
                if (rx_data[15:8] == my) begin
                    if (rx_data == mk(8'h41, my, 8'h41)) begin
                        took = 1;
                        if (m_ph == 2) begin n_led = (m_cnt + 1) % 16; n_ph = 3; end
                        else begin n_cnt = (m_cnt + 1) % 16; n_ph = 0; end
                    end else if (rx_data[7:0] == 8'h4E) begin
                        took = 1; n_err = 1; n_ph = 0;
                    end
                end
            end
            if (!took) begin
                if (m_k == TMO - 1) begin n_err = 1; n_ph = 0; end
                else n_k = m_k + 1;
            end
        end
        chk(cur, "tx_wr", 32'(tx_wr), 32'(e_wr));
        if (e_wr) chk(cur, "tx_data", tx_data, e_data);
        chk(cur, "rx_rd", 32'(rx_rd), 32'(e_rd));
        chk(cur, "led_out", 32'(led_out), 32'(m_led));
        chk(cur, "busy", 32'(busy), 32'(m_ph != 0));
        chk(cur, "err_pulse", 32'(err_pulse), 32'(m_err));
        pop = e_rd;
        @(posedge clk);
        m_ph = n_ph; m_led = n_led; m_cnt = n_cnt; m_k = n_k; m_err = n_err; m_prev = b;
        if (pop) void'(rxq.pop_front());
    endtask

    task automatic run(input int n, input logic b, input logic te);
        for (int i = 0; i < n; i++) step(b, te);
    endtask

    task automatic full_hs();
        run(1, 0, 1);
        run(1, 1, 1);
        run(2, 1, 1);
        rxq.push_back(mk(8'h41, 8'h31, 8'h41));
        run(3, 0, 1);
        rxq.push_back(mk(8'h41, 8'h31, 8'h41));
        run(3, 0, 1);
    endtask

    initial begin
        btn_level = 1'b1;   // high level across reset must not count (R9)
        repeat (3) @(posedge clk);
        // R11 reset state
        chk("R11", "led_out", 32'(led_out), 0);
        chk("R11", "busy", 32'(busy), 0);
        chk("R11", "err_pulse", 32'(err_pulse), 0);
        chk("R11", "tx_wr", 32'(tx_wr), 0);
        @(negedge clk);
        rst_n = 1'b1;
        cur = "R9";
        run(4, 1, 1);

        // R1 / R2: press, outbound mailbox full for a while
        cur = "R1";
        run(1, 0, 0);
        run(1, 1, 0);
        cur = "R2";
        run(3, 1, 0);
        run(1, 1, 1);
        cur = "R3";
        run(3, 1, 1);
        rxq.push_back(mk(8'h41, 8'h31, 8'h41));
        cur = "R4";
        run(4, 0, 1);
        cur = "R5";
        rxq.push_back(mk(8'h41, 8'h31, 8'h41));
        run(4, 0, 1);

        // R9: extra presses during an exchange
        cur = "R9";
        run(1, 1, 1);
        run(1, 0, 1); run(1, 1, 1); run(1, 0, 1);
        rxq.push_back(mk(8'h41, 8'h31, 8'h41));
        run(1, 1, 1); run(1, 0, 1); run(1, 1, 1);
        rxq.push_back(mk(8'h41, 8'h31, 8'h41));
        run(5, 0, 1);

        // R7: foreign replies in both waits
        cur = "R7";
        run(1, 1, 1); run(2, 0, 1);
        rxq.push_back(mk(8'h41, 8'h30, 8'h41));
        rxq.push_back(mk(8'h4E, 8'h32, 8'h4E));
        rxq.push_back(mk(8'h41, 8'h31, 8'h41));
        run(6, 0, 1);
        rxq.push_back(mk(8'h41, 8'h30, 8'h41));
        rxq.push_back(mk(8'h41, 8'h31, 8'h41));
        run(5, 0, 1);

        // R6: negative acknowledge in each wait
        cur = "R6";
        run(1, 1, 1); run(2, 0, 1);
        rxq.push_back(mk(8'h4E, 8'h31, 8'h4E));
        run(4, 0, 1);
        run(1, 1, 1); run(2, 0, 1);
        rxq.push_back(mk(8'h41, 8'h31, 8'h41));
        run(3, 0, 1);
        rxq.push_back(mk(8'h4E, 8'h31, 8'h4E));
        run(4, 0, 1);

        // R8: silent peer in each wait
        cur = "R8";
        run(1, 0, 1); run(1, 1, 1);
        run(TMO + 4, 0, 1);
        run(1, 1, 1); run(2, 0, 1);
        rxq.push_back(mk(8'h41, 8'h31, 8'h41));
        run(TMO + 6, 0, 1);

        // R10: reply queued while idle is left alone, then used as the grant
        cur = "R10";
        rxq.push_back(mk(8'h41, 8'h31, 8'h41));
        run(6, 0, 1);
        run(1, 1, 0);
        run(3, 1, 0);
        run(3, 0, 1);
        rxq.push_back(mk(8'h41, 8'h31, 8'h41));
        run(4, 0, 1);

        // R12: many exchanges through the count wrap
        cur = "R12";
        for (int i = 0; i < 18; i++) full_hs();
        run(3, 0, 1);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule